// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

The block is a 16-bit up-counter that runs continuously from the bus clock. A fixed divide-by-four prescaler sets its rate. An 8-bit CPU reads it through two read-only byte registers on a simple synchronous register bus. Because the CPU needs two accesses to read 16 bits, the block keeps a one-byte holding latch. Reading the high byte freezes the low byte in that latch, so the low-byte read that follows returns a value that matches the high byte already taken, even though the counter has moved on. An overflow flag output is raised when the counter wraps, and it is cleared only through a dedicated clear input.

Two small state machines carry the behaviour.

The prescaler walks `PH_0 -> PH_1 -> PH_2 -> PH_3 -> PH_0`, one step per clock. It emits the count tick while it is in `PH_3`.

The read latch has two states:
- `LAT_LIVE` is the transparent state. It moves to `LAT_HELD` on a high-byte read and captures the live low byte as it does so.
- `LAT_HELD` returns to `LAT_LIVE` on a low-byte read. A further high-byte read leaves it in `LAT_HELD` and does not recapture.

Reset puts the prescaler in `PH_0` and the latch in `LAT_LIVE`.

Top module: `freerun_timer`

## Requirements
- R1: While reset is asserted and at its release, the counter holds 0xFFFC, the overflow flag is 0, the latch is transparent and `rd_data` is 0x00.
- R2: The counter increments by one once every four clocks. The first increment lands on the fourth rising edge after reset is released, so the count repeats every 262,144 clocks.
- R3: When the counter wraps from 0xFFFF to 0x0000, `ovf_flag` reads 1 from the edge of that wrap onward.
- R4: Once set, `ovf_flag` stays set until `ovf_clr` is sampled high at a rising edge. After that edge it reads 0.
- R5: With no high-byte read pending, a read at the low-byte address (`BASE_ADDR + 1`) returns the counter's live bits 7:0.
- R6: A read at the high-byte address (`BASE_ADDR`) returns counter bits 15:8 and captures bits 7:0 at the same edge. Later low-byte reads return the captured byte.
- R7: A further high-byte read while a capture is pending returns the live high byte but leaves the captured low byte unchanged.
- R8: A low-byte read ends the pending capture, so the low-byte read after it returns the live low byte again.
- R9: Writes to either counter address change neither the count, the captured byte, the flag nor `rd_data`.
- R10: Reads in any order or number change neither the counter sequence nor `ovf_flag`.
- R11: `rd_data` is registered and is updated only at the rising edge where `rd_en` is sampled high. A read at any address other than the two counter addresses returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Register address |
| rd_en | input | 1 | Read strobe, one clock per access |
| wr_en | input | 1 | Write strobe (ignored) |
| wr_data | input | 8 | Write data (ignored) |
| rd_data | output | 8 | Registered read data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Every result is due a fixed number of edges after its cause.
- A read's byte appears on `rd_data` one edge after the strobe is sampled. It carries the count as it stood before that edge.
- The counter moves on every fourth edge from reset release. After k edges its value is 0xFFFC + floor(k/4).
- The flag rises on the sixteenth edge and falls one edge after `ovf_clr` is sampled.

The bench drives inputs at falling edges and counts rising edges since reset release. It checks each result at the next falling edge against a model built from that edge count. The model's latch state is updated only by the reads the bench has issued.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_t;

    typedef enum logic {
        LAT_LIVE = 1'b0,
        LAT_HELD = 1'b1
    } latch_t;

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    phase_t phase_q;
    phase_t phase_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_0;
        else        phase_q <= phase_d;
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_0: phase_d = PH_1;
            PH_1: phase_d = PH_2;
            PH_2: phase_d = PH_3;
            PH_3: phase_d = PH_0;
            default: phase_d = PH_0;
        endcase
    end

    // output logic
    always_comb begin
        tick = 1'b0;
        unique case (phase_q)
            PH_3:    tick = 1'b1;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int          CNT_W     = 16,
    parameter logic [15:0] RESET_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_flag
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] INIT     = CNT_W'(RESET_VAL);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wrap;

    assign wrap = tick && (cnt_q == ALL_ONES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= INIT;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // wrap sets the flag; only the clear input drops it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (ovf_clr) flag_q <= 1'b0;
    end

    assign cnt      = cnt_q;
    assign ovf_flag = flag_q;

endmodule

// File: rtl/frt_rd_latch.sv
module frt_rd_latch
    import frt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [BYTE_W-1:0] live_lo,
    output logic [BYTE_W-1:0] lo_view,
    output logic              held,
    output logic [BYTE_W-1:0] hold_byte
);

    latch_t            st_q;
    latch_t            st_d;
    logic [BYTE_W-1:0] hold_q;
    logic              capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LAT_LIVE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= live_lo;
    end

    // next state and capture strobe
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        unique case (st_q)
            LAT_LIVE: begin
                if (hi_rd) begin
                    st_d    = LAT_HELD;
                    capture = 1'b1;
                end
            end
            LAT_HELD: begin
                if (lo_rd) st_d = LAT_LIVE;
            end
            default: st_d = LAT_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        lo_view = live_lo;
        held    = 1'b0;
        unique case (st_q)
            LAT_LIVE: begin
                lo_view = live_lo;
                held    = 1'b0;
            end
            LAT_HELD: begin
                lo_view = hold_q;
                held    = 1'b1;
            end
            default: begin
                lo_view = live_lo;
                held    = 1'b0;
            end
        endcase
    end

    assign hold_byte = hold_q;

endmodule

// File: rtl/freerun_timer.sv
module freerun_timer #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                BYTE_W    = 8,
    parameter logic [15:0]       RESET_VAL = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ovf_clr,
    output logic              ovf_flag
);

    localparam int                CNT_W   = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] LO_ADDR = BASE_ADDR + 1'b1;

    logic              tick;
    logic [CNT_W-1:0]  cnt_q;
    logic              hi_sel;
    logic              lo_sel;
    logic [BYTE_W-1:0] lo_view;
    logic              lat_held;
    logic [BYTE_W-1:0] hold_byte;
    logic [BYTE_W-1:0] rd_q;
    logic              unused_wr;

    // writes have no target in this block
    assign unused_wr = ^{wr_en, wr_data};

    assign hi_sel = (bus_addr == HI_ADDR);
    assign lo_sel = (bus_addr == LO_ADDR);

    frt_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    frt_counter #(
        .CNT_W     (CNT_W),
        .RESET_VAL (RESET_VAL)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt_q),
        .ovf_flag (ovf_flag)
    );

    frt_rd_latch #(
        .BYTE_W (BYTE_W)
    ) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_rd     (rd_en && hi_sel),
        .lo_rd     (rd_en && lo_sel),
        .live_lo   (cnt_q[BYTE_W-1:0]),
        .lo_view   (lo_view),
        .held      (lat_held),
        .hold_byte (hold_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            if (hi_sel)      rd_q <= cnt_q[CNT_W-1:BYTE_W];
            else if (lo_sel) rd_q <= lo_view;
            else             rd_q <= '0;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf_flag,
    input logic              ovf_clr,
    input logic              rd_en,
    input logic              lo_sel,
    input logic              held,
    input logic [BYTE_W-1:0] hold_byte,
    input logic [BYTE_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

    p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |->
            (($past(cnt, 1) == $past(cnt, 2)) && ($past(cnt, 2) == $past(cnt, 3))));

    p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt) == ALL_ONES) && (cnt == '0)) |-> ovf_flag);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(rd_en && lo_sel)) |=> (held && $stable(hold_byte)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lo_sel) |=> !held);

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind freerun_timer frt_checker #(
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .rd_en     (rd_en),
    .lo_sel    (lo_sel),
    .held      (lat_held),
    .hold_byte (hold_byte),
    .rd_data   (rd_data)
);

// File: tb/freerun_timer_tb.sv
module freerun_timer_tb;

    localparam int OP_IDLE = 0;
    localparam int OP_RD   = 1;
    localparam int OP_WR   = 2;
    localparam int NVEC    = 18;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [3:0] req;
    } vec_t;

    // one operation per clock, issued starting 0 edges after reset release
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 4'd1, 8'h00, 4'd2},   // R2: FC
        '{2'd1, 4'd1, 8'h00, 4'd2},
        '{2'd1, 4'd1, 8'h00, 4'd2},
        '{2'd1, 4'd1, 8'h00, 4'd2},   // still FC
        '{2'd1, 4'd1, 8'h00, 4'd2},   // first step: FD
        '{2'd1, 4'd0, 8'h00, 4'd6},   // R6: high read, capture FD
        '{2'd0, 4'd0, 8'h00, 4'd6},
        '{2'd0, 4'd0, 8'h00, 4'd6},
        '{2'd1, 4'd0, 8'h00, 4'd7},   // R7: no recapture
        '{2'd2, 4'd0, 8'h55, 4'd9},   // R9: write high
        '{2'd2, 4'd1, 8'hAA, 4'd9},   // R9: write low
        '{2'd1, 4'd1, 8'h00, 4'd6},   // held FD
        '{2'd1, 4'd1, 8'h00, 4'd8},   // R8: live again
        '{2'd1, 4'd2, 8'h00, 4'd11},  // R11: unmapped
        '{2'd0, 4'd0, 8'h00, 4'd10},
        '{2'd1, 4'd1, 8'h00, 4'd5},   // R5: live FF
        '{2'd1, 4'd0, 8'h00, 4'd3},   // R3: after wrap
        '{2'd1, 4'd1, 8'h00, 4'd8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    logic       m_held = 1'b0;
    logic [7:0] m_hold = '0;
    logic [7:0] m_rd = '0;
    logic       m_flag = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    freerun_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ovf_clr  (ovf_clr),
        .ovf_flag (ovf_flag)
    );

    function automatic logic [15:0] model_cnt(input int edges);
        return 16'(32'hFFFC + edges / 4);
    endfunction

    task automatic check(input int req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h (edge %0d)", req, act, exp, cyc);
        end
    endtask

    // issue one op at a falling edge, check at the next falling edge
    task automatic do_op(input int op, input logic [3:0] addr, input logic [7:0] wd,
                         input int req);
        logic [15:0] c;
        c = model_cnt(cyc);
        bus_addr = addr;
        rd_en    = (op == OP_RD);
        wr_en    = (op == OP_WR);
        wr_data  = wd;
        if (op == OP_RD) begin
            if (addr == 4'd0) begin
                m_rd = c[15:8];
                if (!m_held) begin
                    m_held = 1'b1;
                    m_hold = c[7:0];
                end
            end else if (addr == 4'd1) begin
                m_rd   = m_held ? m_hold : c[7:0];
                m_held = 1'b0;
            end else begin
                m_rd = 8'h00;
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        if (model_cnt(cyc) == 16'h0000 && cyc >= 16) m_flag = 1'b1;
        check(req, int'(rd_data), int'(m_rd));
        check(10, int'(ovf_flag), int'(m_flag)); // R10 and R3 flag tracking
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, int'(rd_data), 0);
        check(1, int'(ovf_flag), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            do_op(int'(VECS[i].op), VECS[i].addr, VECS[i].wdata, int'(VECS[i].req));
        end

        // R4: clear drops the flag, reads do not touch it
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        m_flag  = 1'b0;
        check(4, int'(ovf_flag), 0);
        do_op(OP_RD, 4'd0, 8'h00, 4);
        do_op(OP_RD, 4'd1, 8'h00, 4);

        // R10: long idle run, then a coherent pair still matches the edge model
        repeat (1001) @(negedge clk);
        do_op(OP_RD, 4'd0, 8'h00, 10);
        do_op(OP_RD, 4'd0, 8'h00, 7);
        do_op(OP_WR, 4'd1, 8'h12, 9);
        do_op(OP_RD, 4'd1, 8'h00, 6);
        do_op(OP_RD, 4'd1, 8'h00, 5);

        // R1: reset again mid-run restores the initial value
        rst_n = 1'b0;
        m_held = 1'b0;
        m_rd = '0;
        @(negedge clk);
        check(1, int'(rd_data), 0);
        rst_n = 1'b1;
        do_op(OP_RD, 4'd1, 8'h00, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule